// File: doc/BRIEF.md
# Locality-Driven Page Reference Generator

This block produces a stream of virtual page numbers with tunable locality, meant to drive page-replacement or TLB logic under test. It keeps a current base page inside a virtual space of `PAGES` pages. It emits references in bursts, and each reference falls within a window that starts at the base and spans a configurable width. At the end of each burst a pseudo-random draw picks what happens next. Either the base jumps to a fresh random page, or it moves forward by one and wraps at the top of the space.

A start pulse samples the seed, window width, burst length, total reference count and stability threshold. Generation then runs until the total count has been delivered over a valid/ready output. Each reference takes several cycles. An offset is reduced into range by a bit-serial remainder unit, not by a divider. A done flag marks the end of the run.

Top module: `pg_refgen`

## Requirements
- R1: Every emitted page number lies in 0 to PAGES-1.
- R2: Each reference equals (base + k) mod PAGES. Here k is the low 16 bits of that reference's random draw, modulo (e+1), so k lies in 0..e.
- R3: Random draws come from a 32-bit Galois LFSR. One step shifts the state right by one bit, then XORs in 0x80200003 if the bit shifted out was 1. The seed is loaded at start, and a zero seed is replaced by 1. Each draw advances the LFSR one step and uses the new state. Draws are made in this order: one draw for the initial base, then one per reference, plus one decision draw between bursts.
- R4: Each base serves a burst of m consecutive references, where m is the burst length. A burst length of 0 is treated as 1.
- R5: The initial base is the low 16 bits of the first draw, modulo PAGES. At each burst boundary a decision draw is made. If its upper 16 bits are below the 16-bit threshold, the new base is its low 16 bits modulo PAGES. Otherwise the base becomes (base+1) mod PAGES.
- R6: The window width e is the configured width clamped into the range 2 to WIN_MAX.
- R7: Exactly the configured total number of references is delivered, and then done rises. A total of 0 raises done with no references.
- R8: While out_valid is high and out_ready is low, out_valid and out_page hold steady. The generator advances only on a cycle in which both are high.
- R9: Once done is set, it stays set and out_valid stays low until the next start pulse.
- R10: The configuration inputs and the seed are sampled only on the start pulse. Later changes to them have no effect on the running stream.
- R11: After reset, out_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that samples the configuration and begins a run |
| seed | input | 32 | LFSR seed (zero is replaced by 1) |
| cfg_win | input | WIN_W | Requested window width e |
| cfg_burst | input | BURST_W | References per base (m) |
| cfg_total | input | TOTAL_W | Total references in the run |
| cfg_thresh | input | 16 | Stability threshold as a 16-bit fraction |
| out_valid | output | 1 | A page number is offered |
| out_ready | input | 1 | Consumer accepts the offered page |
| out_page | output | PAGE_W | Offered virtual page number |
| done | output | 1 | Run finished |

## Verification
The bench builds the block with PAGES = 37 and WIN_MAX = 20. A small, non-power-of-two space makes window offsets that run past the top of the space occur often in short runs, and it also lets a step of the base from the last page back to 0 happen. The wrap cases are therefore checked, and so is the clamp of an oversized window request. Threshold values of 0, 0xFFFF and points in between exercise runs that always step, runs that nearly always jump, and mixed runs. Ready patterns with gaps exercise holding the output during a stall.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAW_BASE,
        ST_WAIT_BASE,
        ST_DRAW_OFF,
        ST_WAIT_OFF,
        ST_EMIT,
        ST_DECIDE,
        ST_DONE
    } pg_state_e;

endpackage

// File: rtl/pg_lfsr.sv
module pg_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic [W-1:0] state,
    output logic [W-1:0] state_next
);
    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        state_next = (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : '0);
        lfsr_d     = lfsr_q;
        if (load)
            lfsr_d = (seed == '0) ? W'(1) : seed;
        else if (step)
            lfsr_d = state_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= W'(1);
        else        lfsr_q <= lfsr_d;
    end

    assign state = lfsr_q;

    // R3: the register never falls into the all-zero lockup state
    assert_lfsr_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

endmodule

// File: rtl/pg_modreduce.sv
module pg_modreduce #(
    parameter int VAL_W = 16,
    parameter int MOD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [VAL_W-1:0] value,
    input  logic [MOD_W-1:0] modulus,
    output logic             ready,
    output logic [MOD_W-1:0] rem
);
    localparam int CNT_W = $clog2(VAL_W + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [VAL_W-1:0] val;
        logic [MOD_W-1:0] md;
        logic [MOD_W-1:0] rem;
    } red_t;

    red_t r_d, r_q;
    logic [MOD_W:0] trial;

    always_comb begin
        r_d   = r_q;
        trial = {r_q.rem, r_q.val[VAL_W-1]};
        ready = r_q.busy && (r_q.cnt == '0);
        if (go) begin
            r_d.busy = 1'b1;
            r_d.cnt  = CNT_W'(VAL_W);
            r_d.val  = value;
            r_d.md   = modulus;
            r_d.rem  = '0;
        end else if (r_q.busy) begin
            if (r_q.cnt != '0) begin
                if (trial >= {1'b0, r_q.md})
                    r_d.rem = MOD_W'(trial - {1'b0, r_q.md});
                else
                    r_d.rem = MOD_W'(trial);
                r_d.val = r_q.val << 1;
                r_d.cnt = r_q.cnt - 1'b1;
            end else begin
                r_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rem = r_q.rem;

    // R2: a finished remainder is always below its modulus
    assert_rem_below_mod_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (rem < r_q.md));

endmodule

// File: rtl/pg_refgen.sv
module pg_refgen
    import pg_pkg::*;
#(
    parameter int PAGES   = 1000,
    parameter int WIN_MAX = 100,
    parameter int WIN_W   = 8,
    parameter int BURST_W = 16,
    parameter int TOTAL_W = 32,
    parameter int PAGE_W  = $clog2(PAGES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [31:0]        seed,
    input  logic [WIN_W-1:0]   cfg_win,
    input  logic [BURST_W-1:0] cfg_burst,
    input  logic [TOTAL_W-1:0] cfg_total,
    input  logic [15:0]        cfg_thresh,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PAGE_W-1:0]  out_page,
    output logic               done
);
    localparam int RND_W = 32;
    localparam int HALF  = RND_W / 2;
    localparam int MOD_W = 16;
    localparam int SUM_W = PAGE_W + 1;

    typedef struct packed {
        pg_state_e          state;
        logic [PAGE_W-1:0]  base;
        logic [PAGE_W-1:0]  page;
        logic [WIN_W-1:0]   win;
        logic [BURST_W-1:0] burst;
        logic [TOTAL_W-1:0] total;
        logic [HALF-1:0]    thr;
        logic [TOTAL_W-1:0] refcnt;
        logic [BURST_W-1:0] burstcnt;
        logic               done;
    } gen_t;

    gen_t r_d, r_q;

    logic             lfsr_load, lfsr_step;
    logic [RND_W-1:0] lfsr_cur, lfsr_nxt;
    logic             red_go, red_ready;
    logic [HALF-1:0]  red_val;
    logic [MOD_W-1:0] red_mod, red_rem;
    logic [SUM_W-1:0] sum;
    logic [WIN_W-1:0] win_eff;

    pg_lfsr #(.W(RND_W)) u_lfsr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (lfsr_load),
        .seed       (seed),
        .step       (lfsr_step),
        .state      (lfsr_cur),
        .state_next (lfsr_nxt)
    );

    pg_modreduce #(.VAL_W(HALF), .MOD_W(MOD_W)) u_red (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (red_go),
        .value   (red_val),
        .modulus (red_mod),
        .ready   (red_ready),
        .rem     (red_rem)
    );

    always_comb begin
        if (cfg_win < WIN_W'(2))            win_eff = WIN_W'(2);
        else if (cfg_win > WIN_W'(WIN_MAX)) win_eff = WIN_W'(WIN_MAX);
        else                                win_eff = cfg_win;
    end

    always_comb begin
        r_d       = r_q;
        lfsr_load = 1'b0;
        lfsr_step = 1'b0;
        red_go    = 1'b0;
        red_val   = lfsr_nxt[HALF-1:0];
        red_mod   = MOD_W'(PAGES);
        sum       = {1'b0, r_q.base} + SUM_W'(red_rem);

        unique case (r_q.state)
            ST_DRAW_BASE: begin
                lfsr_step = 1'b1;
                red_go    = 1'b1;
                r_d.state = ST_WAIT_BASE;
            end
            ST_WAIT_BASE: begin
                if (red_ready) begin
                    r_d.base  = PAGE_W'(red_rem);
                    r_d.state = ST_DRAW_OFF;
                end
            end
            ST_DRAW_OFF: begin
                lfsr_step = 1'b1;
                red_go    = 1'b1;
                red_mod   = MOD_W'(r_q.win) + MOD_W'(1);
                r_d.state = ST_WAIT_OFF;
            end
            ST_WAIT_OFF: begin
                if (red_ready) begin
                    if (sum >= SUM_W'(PAGES)) r_d.page = PAGE_W'(sum - SUM_W'(PAGES));
                    else                      r_d.page = PAGE_W'(sum);
                    r_d.state = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    r_d.refcnt = r_q.refcnt + TOTAL_W'(1);
                    if (r_q.refcnt + TOTAL_W'(1) == r_q.total) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_DONE;
                    end else if (r_q.burstcnt + BURST_W'(1) == r_q.burst) begin
                        r_d.burstcnt = '0;
                        r_d.state    = ST_DECIDE;
                    end else begin
                        r_d.burstcnt = r_q.burstcnt + BURST_W'(1);
                        r_d.state    = ST_DRAW_OFF;
                    end
                end
            end
            ST_DECIDE: begin
                lfsr_step = 1'b1;
                if (lfsr_nxt[RND_W-1:HALF] < r_q.thr) begin
                    red_go    = 1'b1;
                    r_d.state = ST_WAIT_BASE;
                end else begin
                    r_d.base  = (r_q.base == PAGE_W'(PAGES - 1)) ? '0
                                                                  : r_q.base + PAGE_W'(1);
                    r_d.state = ST_DRAW_OFF;
                end
            end
            default: ;
        endcase

        if (start) begin
            lfsr_load    = 1'b1;
            lfsr_step    = 1'b0;
            red_go       = 1'b0;
            r_d.win      = win_eff;
            r_d.burst    = (cfg_burst == '0) ? BURST_W'(1) : cfg_burst;
            r_d.total    = cfg_total;
            r_d.thr      = cfg_thresh;
            r_d.refcnt   = '0;
            r_d.burstcnt = '0;
            r_d.done     = (cfg_total == '0);
            r_d.state    = (cfg_total == '0) ? ST_DONE : ST_DRAW_BASE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign out_valid = (r_q.state == ST_EMIT);
    assign out_page  = r_q.page;
    assign done      = r_q.done;

    assert_page_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_page) < PAGES));

    assert_page_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((int'(out_page) + PAGES - int'(r_q.base)) % PAGES) <= int'(r_q.win)));

    assert_burst_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE) |-> (r_q.burstcnt < r_q.burst));

    assert_win_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE) |-> (r_q.win >= WIN_W'(2) && r_q.win <= WIN_W'(WIN_MAX)));

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_page)));

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

endmodule

// File: tb/pg_refgen_tb.sv
module pg_refgen_tb;
    localparam int PAGES   = 37;
    localparam int WIN_MAX = 20;
    localparam int PAGE_W  = $clog2(PAGES);
    localparam int NVEC    = 5;

    typedef struct packed {
        logic [31:0] seed;
        logic [7:0]  win;
        logic [15:0] burst;
        logic [31:0] total;
        logic [15:0] thr;
        logic [7:0]  rpat;
    } vec_t;

    // seed, window, burst, total, threshold, ready pattern
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0001, 8'd5,  16'd4, 32'd30, 16'h0000, 8'hFF},
        '{32'hDEAD_BEEF, 8'd20, 16'd3, 32'd40, 16'h8000, 8'hA5},
        '{32'h0000_0000, 8'd2,  16'd1, 32'd20, 16'hFFFF, 8'h0F},
        '{32'h1234_5678, 8'd0,  16'd0, 32'd15, 16'h4000, 8'hFF},
        '{32'h0000_0007, 8'd31, 16'd7, 32'd50, 16'h2000, 8'h6D}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       seed = '0;
    logic [7:0]        cfg_win = '0;
    logic [15:0]       cfg_burst = '0;
    logic [31:0]       cfg_total = '0;
    logic [15:0]       cfg_thresh = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [PAGE_W-1:0] out_page;
    logic              done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pg_refgen #(.PAGES(PAGES), .WIN_MAX(WIN_MAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
        .cfg_win(cfg_win), .cfg_burst(cfg_burst), .cfg_total(cfg_total),
        .cfg_thresh(cfg_thresh), .out_valid(out_valid), .out_ready(out_ready),
        .out_page(out_page), .done(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL R7 watchdog: cycles=%0d expected below 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // R3: right-shift Galois step with mask 0x80200003
    function automatic logic [31:0] adv(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
    endfunction

    task automatic run_case(input vec_t v, input bit swap_cfg);
        logic [31:0] ml;
        int e, m, mb, off, expp, i, pidx, stall_page;
        bit stall;
        e  = (v.win < 2) ? 2 : ((v.win > WIN_MAX) ? WIN_MAX : int'(v.win)); // R6
        m  = (v.burst == 0) ? 1 : int'(v.burst);                             // R4
        ml = (v.seed == 0) ? 32'd1 : v.seed;                                  // R3
        ml = adv(ml);
        mb = int'(ml[15:0]) % PAGES;                                          // R5
        @(negedge clk);
        seed = v.seed; cfg_win = v.win; cfg_burst = v.burst;
        cfg_total = v.total; cfg_thresh = v.thr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (swap_cfg) begin // R10: late changes must not matter
            seed = ~v.seed; cfg_win = 8'd3; cfg_burst = 16'd9;
            cfg_total = v.total + 5; cfg_thresh = ~v.thr;
        end
        i = 0; pidx = 0; stall = 1'b0; stall_page = 0;
        while (i < int'(v.total)) begin
            if (stall) begin
                check(out_valid && int'(out_page) == stall_page, "R8 hold",
                      int'(out_page), stall_page);
                stall = 1'b0;
            end
            out_ready = v.rpat[pidx % 8];
            pidx++;
            if (out_valid) begin
                if (out_ready) begin
                    if (i > 0 && (i % m) == 0) begin
                        ml = adv(ml);
                        if (ml[31:16] < v.thr) mb = int'(ml[15:0]) % PAGES;
                        else                   mb = (mb + 1) % PAGES;
                    end
                    ml   = adv(ml);
                    off  = int'(ml[15:0]) % (e + 1);
                    expp = (mb + off) % PAGES;
                    check(int'(out_page) < PAGES, "R1 range", int'(out_page), PAGES - 1);
                    check(int'(out_page) == expp, swap_cfg ? "R10 page" : "R2/R5 page",
                          int'(out_page), expp);
                    i++;
                end else begin
                    stall = 1'b1;
                    stall_page = int'(out_page);
                end
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(done == 1'b1, "R7 done after total", int'(done), 1);
        check(out_valid == 1'b0, "R7 no extra reference", int'(out_valid), 0);
        repeat (4) @(negedge clk);
        check(done == 1'b1, "R9 done sticky", int'(done), 1);
        check(out_valid == 1'b0, "R9 quiet while done", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R11 reset valid", int'(out_valid), 0);
        check(done == 1'b0, "R11 reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && done == 1'b0, "R11 idle after reset",
              int'(out_valid) + int'(done), 0);

        for (int k = 0; k < NVEC; k++) run_case(VECS[k], 1'b0);

        // R10: configuration altered right after start
        run_case('{32'hCAFE_F00D, 8'd9, 16'd5, 32'd25, 16'h6000, 8'hDB}, 1'b1);

        // R7: a total of zero finishes at once with no reference
        @(negedge clk);
        cfg_total = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; out_ready = 1'b1;
        check(done == 1'b1, "R7 zero total done", int'(done), 1);
        check(out_valid == 1'b0, "R7 zero total no valid", int'(out_valid), 0);
        repeat (30) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R7 zero total stays quiet", int'(out_valid), 0);
        end
        out_ready = 1'b0;

        // R4: long burst at threshold 0 with the window at the top of the space
        run_case('{32'h0BAD_CAFE, 8'd20, 16'd12, 32'd36, 16'h0000, 8'hF7}, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule